// File: doc/BRIEF.md
# UART Receive Line-Idle Timeout Detector

This block sits beside a UART receiver and watches for silence on the line once a character has arrived. Each time the receiver reports a completed character, an internal counter restarts from zero and counts bit periods. A detected start bit stops the counter. If the count goes past a programmable limit before a new start bit appears, a sticky timeout flag is raised. The flag can also drive an interrupt line.

The limit is given in bit durations and may be rewritten at any time, including while counting is in progress. If the new value is at or below the count already reached, the flag is raised at once. A feature enable switches the whole function on or off. Bit-timing recovery and character decoding belong to the receiver, not to this block.

Top module: `uart_rx_idle_timeout`

## Requirements
- R1: While `rst_n` is low at a clock edge, the flag, the interrupt and the armed state are cleared. After reset the stored limit is 0.
- R2: Before the first `char_done` after enabling, bit ticks never raise `rto_flag`.
- R3: A `char_done` pulse arms the counter and sets the count to zero. Each later `bit_tick` while armed adds one. When the count exceeds the stored limit, `rto_flag` goes high one clock later. With limit L this happens on the clock after the (L+1)-th tick.
- R4: A `start_det` pulse without `char_done` in the same cycle disarms the counter, so no flag follows until another character completes.
- R5: A `char_done` while armed restarts the count from zero.
- R6: A write (`lim_wr` with value V) while armed and enabled, where V is less than or equal to the current count, raises `rto_flag` on the next clock.
- R7: A write of a value above the current count does not raise the flag. Counting continues and is compared against the new value.
- R8: `rto_flag` stays high until `flag_clr` is pulsed. A timeout event in the same cycle as `flag_clr` wins, and the flag stays high.
- R9: `rto_irq` is high exactly when `rto_flag` and `irq_en` are both high.
- R10: While `rto_en` is low, the flag is cleared on the next clock and the counter is disarmed. Raising `rto_en` again does not re-arm it.
- R11: After a timeout the counter stops. Clearing the flag does not bring it back without a new `char_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_done | input | 1 | Receiver finished a character |
| start_det | input | 1 | Receiver detected a start bit |
| rto_en | input | 1 | Timeout function enable |
| irq_en | input | 1 | Timeout interrupt enable |
| lim_val | input | VAL_W (24) | New timeout limit in bit durations |
| lim_wr | input | 1 | Write strobe for `lim_val` |
| flag_clr | input | 1 | Clears the timeout flag |
| rto_flag | output | 1 | Sticky timeout flag |
| rto_irq | output | 1 | Timeout interrupt |

## Verification
Directed sequences cover each distinct line pattern:
- ticks with no character received, which separates an idle counter from a free-running one;
- a quiet line after a character, which pins the exact tick at which the flag rises;
- a start bit mid-count, which shows that the counter stops;
- back-to-back characters, which show that the count restarts;
- limit rewrites just at and just above the reached count, which split the `<=` test from the `<` test;
- clear and disable pulses placed against pending timeouts.

A long stretch of random pulses with small limits then exercises collisions between events in the same cycle. Every cycle is compared against a reference model written from the requirements.

// File: rtl/rto_pkg.sv
// Package: shared widths for the receive timeout detector.
// Assumes the limit is an unsigned count of bit durations.
package rto_pkg;
    parameter int RTO_LIM_W = 24;

    // Counter width: one bit more than the limit, so limit+1 is representable.
    function automatic int rto_cnt_width(input int lim_w);
        return lim_w + 1;
    endfunction
endpackage

// File: rtl/rto_counter.sv
// Module: bit-period counter armed by character completion.
// Zeroes and arms on char_done, disarms on start bit, timeout or disable,
// and adds one per bit tick while armed. The count holds when disarmed.
// Assumes char_done and start_det are single-cycle pulses.
module rto_counter #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             char_done,
    input  logic             start_det,
    input  logic             timeout_ev,
    output logic             armed,
    output logic [CNT_W-1:0] count
);
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    // Arm/disarm control and bit counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!en) begin
            armed_q <= 1'b0;
        end else if (char_done) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (start_det || timeout_ev) begin
            armed_q <= 1'b0;
        end else if (armed_q && tick) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign armed = armed_q;
    assign count = cnt_q;

    // R4
    start_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !char_done) |=> !armed);

    // R11
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_done && !(armed && tick)) |=> $stable(count));

    // R5
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && char_done) |=> (count == '0 && armed));
endmodule

// File: rtl/rto_compare.sv
// Module: holds the timeout limit and decides the timeout event.
// The event fires when armed and enabled and either the count exceeds the
// stored limit or a limit being written is at or below the count.
// Assumes count is at most one above any limit in force.
module rto_compare #(
    parameter int LIM_W = 24,
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             armed,
    input  logic [CNT_W-1:0] count,
    input  logic             wr,
    input  logic [LIM_W-1:0] wr_val,
    output logic             timeout_ev
);
    localparam int PAD_W = CNT_W - LIM_W;

    logic [LIM_W-1:0] lim_q;
    logic             over_lim;
    logic             early_hit;

    // Limit register, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)  lim_q <= '0;
        else if (wr) lim_q <= wr_val;
    end

    // Overrun test against the stored limit, and the at-or-below test on a write.
    always_comb begin
        over_lim   = count > {{PAD_W{1'b0}}, lim_q};
        early_hit  = wr && ({{PAD_W{1'b0}}, wr_val} <= count);
        timeout_ev = en && armed && (over_lim || early_hit);
    end

    // R7
    above_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ({{PAD_W{1'b0}}, wr_val} > count) && !over_lim) |-> !timeout_ev);
endmodule

// File: rtl/rto_flag.sv
// Module: sticky timeout flag.
// Set by a timeout event, cleared by an explicit clear or by disable.
// A set in the same cycle as a clear wins.
module rto_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    // Sticky flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (!en)    flag_q <= 1'b0;
        else if (set_ev) flag_q <= 1'b1;
        else if (clr)    flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R3
    rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_ev));
endmodule

// File: rtl/uart_rx_idle_timeout.sv
// Module: UART receive line-idle timeout detector (top).
// Counts bit periods after each completed character and raises a sticky
// flag plus an optional interrupt when the line stays idle past the limit.
// Assumes bit_tick, char_done, start_det, lim_wr and flag_clr are pulses
// synchronous to clk.
module uart_rx_idle_timeout #(
    parameter int VAL_W = rto_pkg::RTO_LIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             char_done,
    input  logic             start_det,
    input  logic             rto_en,
    input  logic             irq_en,
    input  logic [VAL_W-1:0] lim_val,
    input  logic             lim_wr,
    input  logic             flag_clr,
    output logic             rto_flag,
    output logic             rto_irq
);
    localparam int CNT_W = rto_pkg::rto_cnt_width(VAL_W);

    logic             armed_w;
    logic [CNT_W-1:0] count_w;
    logic             ev_w;

    rto_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rto_en),
        .tick       (bit_tick),
        .char_done  (char_done),
        .start_det  (start_det),
        .timeout_ev (ev_w),
        .armed      (armed_w),
        .count      (count_w)
    );

    rto_compare #(.LIM_W(VAL_W), .CNT_W(CNT_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rto_en),
        .armed      (armed_w),
        .count      (count_w),
        .wr         (lim_wr),
        .wr_val     (lim_val),
        .timeout_ev (ev_w)
    );

    rto_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rto_en),
        .set_ev (ev_w),
        .clr    (flag_clr),
        .flag   (rto_flag)
    );

    // Interrupt gating.
    always_comb rto_irq = rto_flag && irq_en;

    // R10
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rto_en |=> (!rto_flag && !armed_w));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rto_flag && rto_en && !flag_clr) |=> rto_flag);

    // R6
    low_write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_wr && rto_en && armed_w && ({1'b0, lim_val} <= count_w)) |=> rto_flag);

    // R2
    idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_w && !char_done && !rto_flag) |=> !rto_flag);
endmodule

// File: tb/tb_uart_rx_idle_timeout.sv
`timescale 1ns/1ps
module tb_uart_rx_idle_timeout;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_tick = 1'b0, char_done = 1'b0, start_det = 1'b0;
    logic         rto_en = 1'b0, irq_en = 1'b0, lim_wr = 1'b0, flag_clr = 1'b0;
    logic [W-1:0] lim_val = '0;
    logic         rto_flag, rto_irq;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    bit          m_armed = 1'b0;
    bit          m_flag = 1'b0;
    logic [W:0]  m_cnt = '0;
    logic [W-1:0] m_lim = '0;

    uart_rx_idle_timeout dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_done(char_done),
        .start_det(start_det), .rto_en(rto_en), .irq_en(irq_en),
        .lim_val(lim_val), .lim_wr(lim_wr), .flag_clr(flag_clr),
        .rto_flag(rto_flag), .rto_irq(rto_irq)
    );

    always #10 clk = ~clk;

    // Model built from the requirements: event decision, flag, counter, limit.
    function automatic bit model_event();
        return rto_en && m_armed &&
               ((m_cnt > {1'b0, m_lim}) || (lim_wr && ({1'b0, lim_val} <= m_cnt)));
    endfunction

    always @(posedge clk) begin
        bit ev;
        if (!rst_n) begin
            m_armed = 1'b0; m_flag = 1'b0; m_cnt = '0; m_lim = '0;
        end else begin
            ev = model_event();
            if (!rto_en)       m_flag = 1'b0;
            else if (ev)       m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
            if (!rto_en) m_armed = 1'b0;
            else if (char_done) begin m_armed = 1'b1; m_cnt = '0; end
            else if (start_det || ev) m_armed = 1'b0;
            else if (m_armed && bit_tick) m_cnt = m_cnt + 1'b1;
            if (lim_wr) m_lim = lim_val;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of pulses, then compare at the following negedge.
    task automatic cyc(input bit tk, input bit cd, input bit sd,
                       input bit wr, input int val, input bit clr);
        bit_tick = tk; char_done = cd; start_det = sd;
        lim_wr = wr; lim_val = W'(val); flag_clr = clr;
        @(posedge clk);
        @(negedge clk);
        bit_tick = 0; char_done = 0; start_det = 0; lim_wr = 0; flag_clr = 0;
        chk(cur_req, rto_flag, m_flag);
        chk("R9", rto_irq, m_flag && irq_en);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R1", rto_flag, 1'b0);
        chk("R1", rto_irq, 1'b0);
        rst_n = 1'b1;
        rto_en = 1'b1;

        cur_req = "R2"; ticks(30);
        chk("R2", rto_flag, 1'b0);

        cur_req = "R3";
        cyc(0, 0, 0, 1, 4, 0);
        cyc(0, 1, 0, 0, 0, 0);
        ticks(4);
        chk("R3", rto_flag, 1'b0);
        ticks(1);
        chk("R3", rto_flag, 1'b0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R3", rto_flag, 1'b1);

        cur_req = "R9"; irq_en = 1'b1;
        cyc(0, 0, 0, 0, 0, 0);
        chk("R9", rto_irq, 1'b1);

        cur_req = "R8"; ticks(6);
        chk("R8", rto_flag, 1'b1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R8", rto_flag, 1'b0);

        cur_req = "R11"; ticks(20);
        chk("R11", rto_flag, 1'b0);

        cur_req = "R4";
        cyc(0, 1, 0, 0, 0, 0); ticks(2);
        cyc(0, 0, 1, 0, 0, 0); ticks(20);
        chk("R4", rto_flag, 1'b0);

        cur_req = "R5";
        cyc(0, 1, 0, 0, 0, 0); ticks(3);
        cyc(0, 1, 0, 0, 0, 0); ticks(3);
        chk("R5", rto_flag, 1'b0);
        ticks(2); cyc(0, 0, 0, 0, 0, 0);
        chk("R5", rto_flag, 1'b1);
        cyc(0, 0, 0, 0, 0, 1);

        cur_req = "R6";
        cyc(0, 0, 0, 1, 20, 0);
        cyc(0, 1, 0, 0, 0, 0); ticks(6);
        cyc(0, 0, 0, 1, 6, 0);
        chk("R6", rto_flag, 1'b1);
        cyc(0, 0, 0, 0, 0, 1);

        cur_req = "R7";
        cyc(0, 0, 0, 1, 20, 0);
        cyc(0, 1, 0, 0, 0, 0); ticks(6);
        cyc(0, 0, 0, 1, 7, 0);
        chk("R7", rto_flag, 1'b0);
        ticks(2); cyc(0, 0, 0, 0, 0, 0);
        chk("R7", rto_flag, 1'b1);

        cur_req = "R8";
        cyc(0, 1, 0, 1, 0, 0); ticks(1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R8", rto_flag, 1'b1);

        cur_req = "R10";
        cyc(0, 1, 0, 1, 2, 0); ticks(1);
        rto_en = 1'b0; cyc(0, 0, 0, 0, 0, 0);
        chk("R10", rto_flag, 1'b0);
        rto_en = 1'b1; ticks(10);
        chk("R10", rto_flag, 1'b0);

        cur_req = "R3";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 7) == 0) irq_en = ~irq_en;
            rto_en = ($urandom_range(0, 79) != 0);
            cyc($urandom_range(0, 1) == 1,
                $urandom_range(0, 19) == 0,
                $urandom_range(0, 24) == 0,
                $urandom_range(0, 29) == 0,
                int'($urandom_range(0, 12)),
                $urandom_range(0, 14) == 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule